// File: doc/BRIEF.md
# Live-Value-Table Multiport Memory

This block is a synchronous RAM with several independent write ports and several independent read ports, all served in the same clock cycle. The storage is a grid of plain single-write, single-read banks. Each write port has one private bank copy for every read port. A write therefore lands in all the copies that belong to its own port. Several read ports can then all fetch the newest word from the same writer in one cycle without contending for a bank read port.

A register-based table keeps, for each address, the index of the write port that last stored a word there. When a read address is presented, every read port fetches its copy from each writer's bank while looking up the table entry. The looked-up index then steers an M-to-1 selector that picks the winning copy.

Two writes to one address in the same cycle never collide in the banks, because each goes to its own bank. Only the table entry is contested, and the lowest-numbered port takes it. A build-time option chooses whether a read of an address being written in the same cycle returns the previous word or the newly written one.

Top module: `lvt_mpram`

## Requirements
- R1: A word written through any write port is returned on any read port that presents the same address in a later cycle. `rd_data` for a read address sampled at a rising edge is valid after that edge (one-cycle latency).
- R2: All read ports work independently in the same cycle. They may present equal or different addresses and each receives the correct word.
- R3: After successive writes to one address from different ports (or the same port), reads return the value of the most recent write.
- R4: When several write ports write one address in the same cycle, the word from the lowest-numbered port (port 0 before port 1 before port 2) is the one that is stored.
- R5: Writes by different ports to different addresses in the same cycle are all stored.
- R6: With `NEW_ON_COLLIDE` = 0 (the default), a read of an address that is written in the same cycle returns the word held before that write. With `NEW_ON_COLLIDE` = 1, it returns the winning new word.
- R7: A write port whose enable bit is low changes nothing: a following read of the address on its bus returns the word stored earlier.
- R8: While `rst_n` is low, every read port outputs zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset of the table and read registers |
| wr_en | input | NUM_WR | Write enable, bit p for write port p |
| wr_addr | input | NUM_WR*ADDR_W | Write addresses, port p in bits [p*ADDR_W +: ADDR_W] |
| wr_data | input | NUM_WR*DATA_W | Write data, port p in bits [p*DATA_W +: DATA_W] |
| rd_addr | input | NUM_RD*ADDR_W | Read addresses, port r in bits [r*ADDR_W +: ADDR_W] |
| rd_data | output | NUM_RD*DATA_W | Read data, port r in bits [r*DATA_W +: DATA_W] |

## Verification
Every read result is due exactly one rising edge after its address is captured. The bench drives each cycle's writes and read addresses on the falling edge. It samples the read outputs on the next falling edge, half a cycle after the edge that registered them, against expectations stored with that stimulus. A write becomes visible to reads presented from the following cycle on. The bench model takes its expected read values before applying that cycle's writes in lowest-port-first order, which matches the default read-during-write choice. The reset value is checked on the outputs while reset is held, without waiting for a clock edge.

// File: rtl/lvt_pkg.sv
package lvt_pkg;

   // Width of a write-port index; a single writer still needs one bit.
   function automatic int sel_width(input int ports);
      return (ports > 1) ? $clog2(ports) : 1;
   endfunction

endpackage

// File: rtl/lvt_bank.sv
// One write, one read storage bank with a registered read port.
module lvt_bank #(
   parameter int DATA_W         = 16,
   parameter int DEPTH          = 32,
   parameter int ADDR_W         = 5,
   parameter bit NEW_ON_COLLIDE = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [ADDR_W-1:0] wa,
   input  logic [DATA_W-1:0] wd,
   input  logic [ADDR_W-1:0] ra,
   output logic [DATA_W-1:0] q
);

   logic [DATA_W-1:0] mem_q [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem_q[wa] <= wd;
   end

   generate
      if (NEW_ON_COLLIDE) begin : g_fwd
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                q <= '0;
            else if (we && (wa == ra)) q <= wd;
            else                       q <= mem_q[ra];
         end
      end else begin : g_old
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= '0;
            else        q <= mem_q[ra];
         end
      end
   endgenerate

endmodule

// File: rtl/lvt_table.sv
// Register table of last-writer port indices with one registered lookup per read port.
module lvt_table #(
   parameter int NUM_WR         = 3,
   parameter int NUM_RD         = 2,
   parameter int DEPTH          = 32,
   parameter int ADDR_W         = 5,
   parameter int SEL_W          = 2,
   parameter bit NEW_ON_COLLIDE = 1'b0
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [NUM_WR-1:0]        wr_en,
   input  logic [NUM_WR*ADDR_W-1:0] wr_addr,
   input  logic [NUM_RD*ADDR_W-1:0] rd_addr,
   output logic [NUM_RD*SEL_W-1:0]  rd_sel
);

   logic [SEL_W-1:0] tab_q [DEPTH];

   // Highest port is applied first, so the lowest enabled port's update lands last.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int a = 0; a < DEPTH; a++) tab_q[a] <= '0;
      end else begin
         for (int p = NUM_WR - 1; p >= 0; p--) begin
            if (wr_en[p]) tab_q[wr_addr[p*ADDR_W +: ADDR_W]] <= SEL_W'(p);
         end
      end
   end

   generate
      for (genvar r = 0; r < NUM_RD; r++) begin : g_look
         logic [ADDR_W-1:0] ra;
         logic [SEL_W-1:0]  look;
         logic [SEL_W-1:0]  sel_q;

         assign ra = rd_addr[r*ADDR_W +: ADDR_W];

         if (NEW_ON_COLLIDE) begin : g_fwd
            always_comb begin
               look = tab_q[ra];
               for (int p = NUM_WR - 1; p >= 0; p--) begin
                  if (wr_en[p] && (wr_addr[p*ADDR_W +: ADDR_W] == ra)) look = SEL_W'(p);
               end
            end
         end else begin : g_old
            assign look = tab_q[ra];
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sel_q <= '0;
            else        sel_q <= look;
         end

         assign rd_sel[r*SEL_W +: SEL_W] = sel_q;
      end
   endgenerate

endmodule

// File: rtl/lvt_mpram.sv
// Multiport RAM: NUM_WR x NUM_RD bank grid steered by a live value table.
module lvt_mpram
   import lvt_pkg::*;
#(
   parameter int NUM_WR         = 3,
   parameter int NUM_RD         = 2,
   parameter int DATA_W         = 16,
   parameter int DEPTH          = 32,
   parameter bit NEW_ON_COLLIDE = 1'b0
) (
   input  logic                                    clk,
   input  logic                                    rst_n,
   input  logic [NUM_WR-1:0]                       wr_en,
   input  logic [NUM_WR*$clog2(DEPTH)-1:0]         wr_addr,
   input  logic [NUM_WR*DATA_W-1:0]                wr_data,
   input  logic [NUM_RD*$clog2(DEPTH)-1:0]         rd_addr,
   output logic [NUM_RD*DATA_W-1:0]                rd_data
);

   localparam int ADDR_W = $clog2(DEPTH);
   localparam int SEL_W  = sel_width(NUM_WR);
   localparam int NBANK  = NUM_WR * NUM_RD;

   if (NUM_WR < 1) begin : g_bad_wr
      $error("lvt_mpram: NUM_WR must be at least 1");
   end
   if (NUM_RD < 1) begin : g_bad_rd
      $error("lvt_mpram: NUM_RD must be at least 1");
   end
   if (DEPTH < 2) begin : g_bad_depth
      $error("lvt_mpram: DEPTH must be at least 2");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("lvt_mpram: DATA_W must be at least 1");
   end

   logic [NBANK*DATA_W-1:0]  bank_q;
   logic [NUM_RD*SEL_W-1:0]  rd_sel;

   lvt_table #(
      .NUM_WR         (NUM_WR),
      .NUM_RD         (NUM_RD),
      .DEPTH          (DEPTH),
      .ADDR_W         (ADDR_W),
      .SEL_W          (SEL_W),
      .NEW_ON_COLLIDE (NEW_ON_COLLIDE)
   ) u_table (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .rd_addr (rd_addr),
      .rd_sel  (rd_sel)
   );

   // Bank (w, r): written only by write port w, read only by read port r.
   generate
      for (genvar w = 0; w < NUM_WR; w++) begin : g_wr
         for (genvar r = 0; r < NUM_RD; r++) begin : g_rd
            lvt_bank #(
               .DATA_W         (DATA_W),
               .DEPTH          (DEPTH),
               .ADDR_W         (ADDR_W),
               .NEW_ON_COLLIDE (NEW_ON_COLLIDE)
            ) u_bank (
               .clk   (clk),
               .rst_n (rst_n),
               .we    (wr_en[w]),
               .wa    (wr_addr[w*ADDR_W +: ADDR_W]),
               .wd    (wr_data[w*DATA_W +: DATA_W]),
               .ra    (rd_addr[r*ADDR_W +: ADDR_W]),
               .q     (bank_q[(w*NUM_RD + r)*DATA_W +: DATA_W])
            );
         end
      end

      for (genvar r = 0; r < NUM_RD; r++) begin : g_mux
         logic [DATA_W-1:0] word;
         always_comb begin
            word = '0;
            for (int p = 0; p < NUM_WR; p++) begin
               if (rd_sel[r*SEL_W +: SEL_W] == SEL_W'(p))
                  word = bank_q[(p*NUM_RD + r)*DATA_W +: DATA_W];
            end
         end
         assign rd_data[r*DATA_W +: DATA_W] = word;
      end
   endgenerate

endmodule

// File: rtl/lvt_mpram_chk.sv
// Port-level checker for lvt_mpram, attached by bind.
module lvt_mpram_chk #(
   parameter int NUM_WR         = 3,
   parameter int NUM_RD         = 2,
   parameter int DATA_W         = 16,
   parameter int DEPTH          = 32,
   parameter bit NEW_ON_COLLIDE = 1'b0
) (
   input logic                            clk,
   input logic                            rst_n,
   input logic [NUM_WR-1:0]               wr_en,
   input logic [NUM_WR*$clog2(DEPTH)-1:0] wr_addr,
   input logic [NUM_WR*DATA_W-1:0]        wr_data,
   input logic [NUM_RD*$clog2(DEPTH)-1:0] rd_addr,
   input logic [NUM_RD*DATA_W-1:0]        rd_data
);

   localparam int ADDR_W = $clog2(DEPTH);

   // Shadow contents under lowest-port-wins.
   logic [DATA_W-1:0]        shd_q [DEPTH];
   logic [DEPTH-1:0]         shv_q;
   logic [NUM_RD-1:0]        chk_q;
   logic [NUM_RD*DATA_W-1:0] exp_q;
   logic [1:0]               up_q;
   logic                     idle_q;
   logic                     w0v_q;
   logic [ADDR_W-1:0]        w0a_q;
   logic [DATA_W-1:0]        w0d_q;
   logic [NUM_RD-1:0]        pc_q;
   logic [NUM_RD*DATA_W-1:0] pd_q;

   always_ff @(posedge clk) begin
      for (int p = NUM_WR - 1; p >= 0; p--) begin
         if (wr_en[p]) shd_q[wr_addr[p*ADDR_W +: ADDR_W]] <= wr_data[p*DATA_W +: DATA_W];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shv_q  <= '0;
         chk_q  <= '0;
         exp_q  <= '0;
         up_q   <= '0;
         idle_q <= 1'b1;
         w0v_q  <= 1'b0;
         w0a_q  <= '0;
         w0d_q  <= '0;
         pc_q   <= '0;
         pd_q   <= '0;
      end else begin
         if (up_q != 2'd3) up_q <= up_q + 2'd1;
         idle_q <= (wr_en == '0);
         w0v_q  <= wr_en[0];
         w0a_q  <= wr_addr[0 +: ADDR_W];
         w0d_q  <= wr_data[0 +: DATA_W];
         for (int r = 0; r < NUM_RD; r++) begin
            chk_q[r] <= shv_q[rd_addr[r*ADDR_W +: ADDR_W]];
            exp_q[r*DATA_W +: DATA_W] <= shd_q[rd_addr[r*ADDR_W +: ADDR_W]];
            if (NEW_ON_COLLIDE) begin
               for (int p = NUM_WR - 1; p >= 0; p--) begin
                  if (wr_en[p] && (wr_addr[p*ADDR_W +: ADDR_W] == rd_addr[r*ADDR_W +: ADDR_W])) begin
                     chk_q[r] <= 1'b1;
                     exp_q[r*DATA_W +: DATA_W] <= wr_data[p*DATA_W +: DATA_W];
                  end
               end
            end
            pc_q[r] <= w0v_q && (rd_addr[r*ADDR_W +: ADDR_W] == w0a_q);
            for (int p = 0; p < NUM_WR; p++) begin
               if (wr_en[p] && (wr_addr[p*ADDR_W +: ADDR_W] == w0a_q)) pc_q[r] <= 1'b0;
            end
            pd_q[r*DATA_W +: DATA_W] <= w0d_q;
         end
         for (int p = NUM_WR - 1; p >= 0; p--) begin
            if (wr_en[p]) shv_q[wr_addr[p*ADDR_W +: ADDR_W]] <= 1'b1;
         end
      end
   end

   always @(posedge clk) begin
      if (!rst_n) begin
         assert_reset_zero_R8: assert (rd_data == '0)
            else $error("rd_data not zero during reset");
      end
   end

   generate
      for (genvar r = 0; r < NUM_RD; r++) begin : g_port
         assert_read_data_R1: assert property (@(posedge clk) disable iff (!rst_n)
            chk_q[r] |-> (rd_data[r*DATA_W +: DATA_W] == exp_q[r*DATA_W +: DATA_W]))
            else $error("read port %0d returned a wrong word", r);

         assert_port0_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
            pc_q[r] |-> (rd_data[r*DATA_W +: DATA_W] == pd_q[r*DATA_W +: DATA_W]))
            else $error("read port %0d lost a port 0 write", r);

         assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
            ((up_q >= 2'd2) && idle_q && $stable(rd_addr[r*ADDR_W +: ADDR_W]) &&
             (!NEW_ON_COLLIDE || (wr_en == '0)))
            |=> $stable(rd_data[r*DATA_W +: DATA_W]))
            else $error("read port %0d changed without a write", r);
      end
   endgenerate

endmodule

bind lvt_mpram lvt_mpram_chk #(
   .NUM_WR         (NUM_WR),
   .NUM_RD         (NUM_RD),
   .DATA_W         (DATA_W),
   .DEPTH          (DEPTH),
   .NEW_ON_COLLIDE (NEW_ON_COLLIDE)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .wr_en   (wr_en),
   .wr_addr (wr_addr),
   .wr_data (wr_data),
   .rd_addr (rd_addr),
   .rd_data (rd_data)
);

// File: tb/sim_lvt_mpram.sv
module sim_lvt_mpram;

   localparam int NW  = 3;
   localparam int NR  = 2;
   localparam int DW  = 16;
   localparam int DEP = 32;
   localparam int AW  = 5;

   typedef struct packed {
      logic [NW-1:0]    we;
      logic [NW*AW-1:0] wa;   // {port2, port1, port0}
      logic [NW*DW-1:0] wd;   // {port2, port1, port0}
      logic [NR*AW-1:0] ra;   // {port1, port0}
   } vec_t;

   localparam int NVEC = 14;

   localparam vec_t VECS [NVEC] = '{
      '{3'b001, {5'd0, 5'd0, 5'd1},    {16'h0, 16'h0, 16'h1111},          {5'd0, 5'd0}},
      '{3'b010, {5'd0, 5'd2, 5'd0},    {16'h0, 16'h2222, 16'h0},          {5'd1, 5'd1}},
      '{3'b100, {5'd3, 5'd0, 5'd0},    {16'h3333, 16'h0, 16'h0},          {5'd3, 5'd2}},
      '{3'b111, {5'd5, 5'd5, 5'd5},    {16'h0C0C, 16'h0B0B, 16'h0A0A},    {5'd2, 5'd3}},
      '{3'b000, {5'd0, 5'd0, 5'd0},    {16'h0, 16'h0, 16'h0},             {5'd5, 5'd5}},
      '{3'b110, {5'd6, 5'd6, 5'd0},    {16'h1C1C, 16'h1B1B, 16'h0},       {5'd1, 5'd5}},
      '{3'b001, {5'd0, 5'd0, 5'd1},    {16'h0, 16'h0, 16'h4444},          {5'd6, 5'd6}},
      '{3'b010, {5'd0, 5'd1, 5'd0},    {16'h0, 16'h5555, 16'h0},          {5'd6, 5'd1}},
      '{3'b000, {5'd1, 5'd1, 5'd1},    {16'hBEEF, 16'hCAFE, 16'hDEAD},    {5'd1, 5'd1}},
      '{3'b000, {5'd0, 5'd0, 5'd0},    {16'h0, 16'h0, 16'h0},             {5'd2, 5'd1}},
      '{3'b111, {5'd12, 5'd11, 5'd10}, {16'h7C7C, 16'h7B7B, 16'h7A7A},    {5'd6, 5'd5}},
      '{3'b000, {5'd0, 5'd0, 5'd0},    {16'h0, 16'h0, 16'h0},             {5'd12, 5'd11}},
      '{3'b000, {5'd0, 5'd0, 5'd0},    {16'h0, 16'h0, 16'h0},             {5'd31, 5'd10}},
      '{3'b000, {5'd0, 5'd0, 5'd0},    {16'h0, 16'h0, 16'h0},             {5'd10, 5'd10}}
   };

   // Requirement named by the checks whose stimulus is issued in each step.
   localparam string TAGS [NVEC] = '{
      "R1 first write",
      "R1 R2 same address",
      "R2 different addresses",
      "R2 before collision",
      "R4 three-way collision",
      "R4 R1 keep",
      "R4 ports 1 and 2",
      "R6 read during write",
      "R3 R7 disabled write",
      "R7 R2 after disabled",
      "R5 parallel writes",
      "R5 check",
      "R5 check",
      "R5 check"
   };

   logic                clk = 1'b0;
   logic                rst_n = 1'b0;
   logic [NW-1:0]       wr_en = '0;
   logic [NW*AW-1:0]    wr_addr = '0;
   logic [NW*DW-1:0]    wr_data = '0;
   logic [NR*AW-1:0]    rd_addr = '0;
   logic [NR*DW-1:0]    rd_data;

   int n_chk = 0;
   int n_fail = 0;

   logic [DW-1:0] mdl [DEP];
   bit            mv  [DEP];
   bit            pend_chk [NR];
   logic [DW-1:0] pend_exp [NR];
   string         pend_tag = "";
   logic [31:0]   lfsr = 32'h1234_5678;

   always #5 clk = ~clk;

   lvt_mpram #(
      .NUM_WR         (NW),
      .NUM_RD         (NR),
      .DATA_W         (DW),
      .DEPTH          (DEP),
      .NEW_ON_COLLIDE (1'b0)
   ) u0 (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .rd_addr (rd_addr),
      .rd_data (rd_data)
   );

   task automatic check_pending();
      for (int r = 0; r < NR; r++) begin
         if (pend_chk[r]) begin
            n_chk++;
            if (rd_data[r*DW +: DW] !== pend_exp[r]) begin
               n_fail++;
               $display("FAIL %s read port %0d: actual %h expected %h",
                        pend_tag, r, rd_data[r*DW +: DW], pend_exp[r]);
            end
         end
      end
   endtask

   // One cycle: check last cycle's reads, predict this cycle's, drive.
   task automatic step(input logic [NW-1:0] we, input logic [NW*AW-1:0] wa,
                       input logic [NW*DW-1:0] wd, input logic [NR*AW-1:0] ra,
                       input string tag);
      @(negedge clk);
      check_pending();
      for (int r = 0; r < NR; r++) begin
         pend_chk[r] = mv[ra[r*AW +: AW]];
         pend_exp[r] = mdl[ra[r*AW +: AW]];
      end
      pend_tag = tag;
      for (int p = NW - 1; p >= 0; p--) begin
         if (we[p]) begin
            mdl[wa[p*AW +: AW]] = wd[p*DW +: DW];
            mv[wa[p*AW +: AW]]  = 1'b1;
         end
      end
      wr_en   = we;
      wr_addr = wa;
      wr_data = wd;
      rd_addr = ra;
   endtask

   task automatic check_reset_zero(input string tag);
      n_chk++;
      if (rd_data !== '0) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, rd_data, {NR*DW{1'b0}});
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      for (int a = 0; a < DEP; a++) begin
         mdl[a] = '0;
         mv[a]  = 1'b0;
      end
      for (int r = 0; r < NR; r++) begin
         pend_chk[r] = 1'b0;
         pend_exp[r] = '0;
      end

      // R8: outputs held at zero while reset is low.
      repeat (3) @(negedge clk);
      check_reset_zero("R8 initial reset");
      rst_n = 1'b1;

      for (int v = 0; v < NVEC; v++) begin
         step(VECS[v].we, VECS[v].wa, VECS[v].wd, VECS[v].ra, TAGS[v]);
      end

      // Pseudo-random traffic on a narrow address range to force collisions (R3 R4 R5).
      for (int i = 0; i < 400; i++) begin
         logic [NW*AW-1:0] wa;
         logic [NW*DW-1:0] wd;
         logic [NR*AW-1:0] ra;
         lfsr = lfsr ^ (lfsr << 13);
         lfsr = lfsr ^ (lfsr >> 17);
         lfsr = lfsr ^ (lfsr << 5);
         for (int p = 0; p < NW; p++) begin
            wa[p*AW +: AW] = {2'b00, lfsr[p*3 +: 3]};
            wd[p*DW +: DW] = lfsr[31:16] ^ DW'(p * 16'h1357 + i);
         end
         for (int r = 0; r < NR; r++) ra[r*AW +: AW] = {2'b00, lfsr[9 + r*3 +: 3]};
         step(lfsr[14:12], wa, wd, ra, "R3 R4 R5 random traffic");
      end
      step('0, '0, '0, '0, "R1 drain");
      @(negedge clk);
      check_pending();

      // R8: asserting reset mid-run clears the read outputs at once.
      rst_n = 1'b0;
      #1;
      check_reset_zero("R8 reset after traffic");

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule